// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a parallel flash bus and the operation engine of a byte-wide flash array. It watches bus write cycles and recognises the standard unlock-prefixed command set. Every command opens with two unlock writes. A third write then either arms a byte program, arms an erase that needs a second unlock pair and a selector write, enters or leaves the identification mode. For each recognised command the block emits a one-cycle strobe. The strobe comes with the target address and data byte that the operation engine needs.

The bus pins are sampled on the system clock. A write spans the cycles in which chip-enable and write-enable are both low while output-enable is high. The address is captured in the first cycle of that span. The data is captured in its last cycle. While identification mode is active, reads return a manufacturer code or a device code. The engine holds `busy` high while an operation runs, and all writes are dropped during that time. A write that does not fit the expected next step sends the decoder back to its idle read state and produces no strobe.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous reset, all six strobes, `id_mode` and `id_rd_valid` are low.
- R2: A write is a run of clock cycles with `bus_ce_n`=0, `bus_we_n`=0 and `bus_oe_n`=1. Its address is sampled in the first cycle of the run and its data in the last cycle. A run with `bus_oe_n`=0 is not a write.
- R3: Unlock and selector cycles compare only address bits [10:0] against 555h and 2AAh. Higher address bits are ignored.
- R4: The writes AAh@555h, 55h@2AAh, A0h@555h followed by any write pulse `prog_stb`. The same cycle presents the fourth write's full address on `op_addr` and its data on `op_data`.
- R5: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 30h@X pulse `sect_erase_stb`. `op_addr` carries X with bits below 12 cleared.
- R6: The same five-write prefix followed by 50h@X pulses `blk_erase_stb`. `op_addr` carries X with bits below 16 cleared.
- R7: The same prefix followed by 10h@555h pulses `chip_erase_stb` with `op_addr`=0.
- R8: AAh@555h, 55h@2AAh, 90h@555h pulse `id_enter_stb`, and `id_mode` is 1 in that same cycle.
- R9: A read is `bus_ce_n`=0, `bus_oe_n`=0, `bus_we_n`=1. A read made while `id_mode`=1 sets `id_rd_valid` one clock later. The returned data is 9Dh when address bits [1:0]=0, 3Eh when they are 1, and 00h otherwise; all other address bits are ignored. A read made while `id_mode`=0 leaves `id_rd_valid` low.
- R10: ID mode is left in either of two ways: a single F0h write to any address from idle, or AAh@555h, 55h@2AAh, F0h@555h. Either pulses `id_exit_stb` and clears `id_mode`. Neither pulses `id_exit_stb` when `id_mode` was already 0.
- R11: A write that does not match the expected next step returns the decoder to idle with no strobe. A following write that would only be valid mid-sequence then has no effect.
- R12: A write completed while `busy`=1 is ignored: it produces no strobe and does not advance or reset the sequence.
- R13: No more than one strobe is high in any cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr | input | AW | Bus address |
| bus_wdata | input | 8 | Bus write data |
| busy | input | 1 | Operation engine running; writes ignored |
| prog_stb | output | 1 | Byte program request |
| sect_erase_stb | output | 1 | Sector erase request |
| blk_erase_stb | output | 1 | Block erase request |
| chip_erase_stb | output | 1 | Chip erase request |
| id_enter_stb | output | 1 | Identification mode entered |
| id_exit_stb | output | 1 | Identification mode left |
| op_addr | output | AW | Target address for the strobed operation |
| op_data | output | 8 | Data byte for the strobed operation |
| id_mode | output | 1 | Identification mode active |
| id_rd_valid | output | 1 | Identification read data valid |
| id_rd_data | output | 8 | Identification read data |

## Verification
The command decoder is driven with every complete sequence, including both ways out of identification mode. Each sequence distinguishes its own opcode from the shared prefix, and the aligned target addresses show that the sector and block fields are cut at the right bit. Broken sequences also run: a wrong unlock address, and an erase prefix aborted at its fifth write. These separate a decoder that returns to idle from one that resumes mid-sequence. Unlock addresses with high bits set show that only the low eleven bits are compared. Writes with output-enable low, multi-cycle write windows and writes under `busy` show what is discarded, held or captured at the bus edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PGM,
    SQ_ERA1,
    SQ_ERA2,
    SQ_ERA3
  } seq_state_t;

  localparam int STB_W     = 6;
  localparam int STB_PROG  = 0;
  localparam int STB_SECT  = 1;
  localparam int STB_BLK   = 2;
  localparam int STB_CHIP  = 3;
  localparam int STB_IDIN  = 4;
  localparam int STB_IDOUT = 5;

  localparam logic [7:0] CD_KEY1  = 8'hAA;
  localparam logic [7:0] CD_KEY2  = 8'h55;
  localparam logic [7:0] CD_PGM   = 8'hA0;
  localparam logic [7:0] CD_ERA   = 8'h80;
  localparam logic [7:0] CD_IDIN  = 8'h90;
  localparam logic [7:0] CD_IDOUT = 8'hF0;
  localparam logic [7:0] CD_CHIP  = 8'h10;
  localparam logic [7:0] CD_SECT  = 8'h30;
  localparam logic [7:0] CD_BLK   = 8'h50;

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);

  logic win;
  logic win_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;

  // write window: both strobes low, outputs not driven
  assign win = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= 1'b0;
      wr_valid <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      win_q    <= win;
      wr_valid <= win_q && !win;
      if (win && !win_q) addr_q <= addr;
      if (win)           data_q <= wdata;
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = data_q;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 19,
  parameter int CMP_W    = 11,
  parameter int SECT_LSB = 12,
  parameter int BLK_LSB  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             busy,
  output logic [STB_W-1:0] stb,
  output logic [AW-1:0]    op_addr,
  output logic [7:0]       op_data,
  output logic             id_mode
);

  localparam logic [CMP_W-1:0] KEY_ADDR1 = CMP_W'(11'h555);
  localparam logic [CMP_W-1:0] KEY_ADDR2 = CMP_W'(11'h2AA);

  seq_state_t        state_q, state_d;
  logic [STB_W-1:0]  stb_q, stb_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic              idm_q, idm_d;
  logic              at_k1, at_k2;
  logic [AW-1:0]     sect_base, blk_base;

  assign at_k1 = (wr_addr[CMP_W-1:0] == KEY_ADDR1);
  assign at_k2 = (wr_addr[CMP_W-1:0] == KEY_ADDR2);
  assign sect_base = {wr_addr[AW-1:SECT_LSB], {SECT_LSB{1'b0}}};
  assign blk_base  = {wr_addr[AW-1:BLK_LSB],  {BLK_LSB{1'b0}}};

  always_comb begin
    state_d = state_q;
    stb_d   = '0;
    addr_d  = addr_q;
    data_d  = data_q;
    idm_d   = idm_q;
    if (wr_valid && !busy) begin
      state_d = SQ_IDLE;
      unique case (state_q)
        SQ_IDLE: begin
          if (at_k1 && wr_data == CD_KEY1) begin
            state_d = SQ_UNL1;
          end else if (idm_q && wr_data == CD_IDOUT) begin
            stb_d[STB_IDOUT] = 1'b1;
            idm_d            = 1'b0;
          end
        end
        SQ_UNL1: begin
          if (at_k2 && wr_data == CD_KEY2) state_d = SQ_UNL2;
        end
        SQ_UNL2: begin
          if (at_k1) begin
            case (wr_data)
              CD_PGM: state_d = SQ_PGM;
              CD_ERA: state_d = SQ_ERA1;
              CD_IDIN: begin
                stb_d[STB_IDIN] = 1'b1;
                idm_d           = 1'b1;
              end
              CD_IDOUT: begin
                if (idm_q) begin
                  stb_d[STB_IDOUT] = 1'b1;
                  idm_d            = 1'b0;
                end
              end
              default: state_d = SQ_IDLE;
            endcase
          end
        end
        SQ_PGM: begin
          stb_d[STB_PROG] = 1'b1;
          addr_d          = wr_addr;
          data_d          = wr_data;
        end
        SQ_ERA1: begin
          if (at_k1 && wr_data == CD_KEY1) state_d = SQ_ERA2;
        end
        SQ_ERA2: begin
          if (at_k2 && wr_data == CD_KEY2) state_d = SQ_ERA3;
        end
        SQ_ERA3: begin
          if (at_k1 && wr_data == CD_CHIP) begin
            stb_d[STB_CHIP] = 1'b1;
            addr_d          = '0;
            data_d          = wr_data;
          end else if (wr_data == CD_SECT) begin
            stb_d[STB_SECT] = 1'b1;
            addr_d          = sect_base;
            data_d          = wr_data;
          end else if (wr_data == CD_BLK) begin
            stb_d[STB_BLK] = 1'b1;
            addr_d         = blk_base;
            data_d         = wr_data;
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      stb_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      idm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= stb_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      idm_q   <= idm_d;
    end
  end

  assign stb     = stb_q;
  assign op_addr = addr_q;
  assign op_data = data_q;
  assign id_mode = idm_q;

endmodule

// File: rtl/flash_id_reader.sv
module flash_id_reader #(
  parameter int         AW     = 19,
  parameter logic [7:0] MFR_ID = 8'h9D,
  parameter logic [7:0] DEV_ID = 8'h3E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          id_mode,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  output logic          rd_valid,
  output logic [7:0]    rd_data
);

  logic       rd_cyc;
  logic [7:0] sel;

  assign rd_cyc = !ce_n && !oe_n && we_n;

  always_comb begin
    case (addr[1:0])
      2'd0:    sel = MFR_ID;
      2'd1:    sel = DEV_ID;
      default: sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_cyc && id_mode;
      if (rd_cyc && id_mode) rd_data <= sel;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int         AW       = 19,
  parameter int         CMP_W    = 11,
  parameter int         SECT_LSB = 12,
  parameter int         BLK_LSB  = 16,
  parameter logic [7:0] MFR_ID   = 8'h9D,
  parameter logic [7:0] DEV_ID   = 8'h3E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_ce_n,
  input  logic          bus_we_n,
  input  logic          bus_oe_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          busy,
  output logic          prog_stb,
  output logic          sect_erase_stb,
  output logic          blk_erase_stb,
  output logic          chip_erase_stb,
  output logic          id_enter_stb,
  output logic          id_exit_stb,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          id_mode,
  output logic          id_rd_valid,
  output logic [7:0]    id_rd_data
);

  logic             wr_valid;
  logic [AW-1:0]    wr_addr;
  logic [7:0]       wr_data;
  logic [STB_W-1:0] stb_vec;

  flash_bus_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst(rst),
    .ce_n(bus_ce_n), .we_n(bus_we_n), .oe_n(bus_oe_n),
    .addr(bus_addr), .wdata(bus_wdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  flash_cmd_seq #(
    .AW(AW), .CMP_W(CMP_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
  ) u_seq (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy),
    .stb(stb_vec), .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode)
  );

  flash_id_reader #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
    .clk(clk), .rst(rst), .id_mode(id_mode),
    .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n), .addr(bus_addr),
    .rd_valid(id_rd_valid), .rd_data(id_rd_data)
  );

  assign prog_stb       = stb_vec[STB_PROG];
  assign sect_erase_stb = stb_vec[STB_SECT];
  assign blk_erase_stb  = stb_vec[STB_BLK];
  assign chip_erase_stb = stb_vec[STB_CHIP];
  assign id_enter_stb   = stb_vec[STB_IDIN];
  assign id_exit_stb    = stb_vec[STB_IDOUT];

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int AW       = 19,
  parameter int SECT_LSB = 12,
  parameter int BLK_LSB  = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic [5:0]    stb,
  input logic [AW-1:0] op_addr,
  input logic          id_mode,
  input logic          id_rd_valid
);

  assert_onehot_stb_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));

  assert_pulse_stb_R13: assert property (@(posedge clk) disable iff (rst)
    (stb != 6'b0) |=> (stb == 6'b0));

  assert_busy_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    busy |=> (stb == 6'b0));

  assert_enter_mode_R8: assert property (@(posedge clk) disable iff (rst)
    stb[4] |-> id_mode);

  assert_exit_mode_R10: assert property (@(posedge clk) disable iff (rst)
    stb[5] |-> (!id_mode && $past(id_mode)));

  assert_idrd_mode_R9: assert property (@(posedge clk) disable iff (rst)
    id_rd_valid |-> $past(id_mode));

  assert_chip_addr_R7: assert property (@(posedge clk) disable iff (rst)
    stb[3] |-> (op_addr == '0));

  assert_sect_align_R5: assert property (@(posedge clk) disable iff (rst)
    stb[1] |-> (op_addr[SECT_LSB-1:0] == '0));

  assert_blk_align_R6: assert property (@(posedge clk) disable iff (rst)
    stb[2] |-> (op_addr[BLK_LSB-1:0] == '0));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .AW(AW), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .stb(stb_vec),
  .op_addr(op_addr), .id_mode(id_mode), .id_rd_valid(id_rd_valid)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

  localparam int AW = 19;
  localparam int NV = 46;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic prog_stb, sect_erase_stb, blk_erase_stb, chip_erase_stb;
  logic id_enter_stb, id_exit_stb, id_mode, id_rd_valid;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data, id_rd_data;

  int checks = 0;
  int failures = 0;

  logic [5:0]    s_stb;
  logic [AW-1:0] s_addr;
  logic [7:0]    s_data;

  always #2.5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst(rst),
    .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_addr(addr), .bus_wdata(wdata), .busy(busy),
    .prog_stb(prog_stb), .sect_erase_stb(sect_erase_stb),
    .blk_erase_stb(blk_erase_stb), .chip_erase_stb(chip_erase_stb),
    .id_enter_stb(id_enter_stb), .id_exit_stb(id_exit_stb),
    .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode),
    .id_rd_valid(id_rd_valid), .id_rd_data(id_rd_data)
  );

  // {addr, data, strobes {idout,idin,chip,blk,sect,prog}, expected op_addr}
  localparam logic [51:0] VEC [NV] = '{
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AA, 8'h55, 6'b000000, 19'h00000},
    {19'h00555, 8'hA0, 6'b000000, 19'h00000},
    {19'h12345, 8'h5A, 6'b000001, 19'h12345},
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AA, 8'h55, 6'b000000, 19'h00000},
    {19'h00555, 8'h80, 6'b000000, 19'h00000},
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AA, 8'h55, 6'b000000, 19'h00000},
    {19'h23456, 8'h30, 6'b000010, 19'h23000},
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AA, 8'h55, 6'b000000, 19'h00000},
    {19'h00555, 8'h80, 6'b000000, 19'h00000},
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AA, 8'h55, 6'b000000, 19'h00000},
    {19'h34567, 8'h50, 6'b000100, 19'h30000},
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AA, 8'h55, 6'b000000, 19'h00000},
    {19'h00555, 8'h80, 6'b000000, 19'h00000},
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AA, 8'h55, 6'b000000, 19'h00000},
    {19'h00555, 8'h10, 6'b001000, 19'h00000},
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AA, 8'h55, 6'b000000, 19'h00000},
    {19'h00555, 8'h90, 6'b010000, 19'h00000},
    {19'h7FFFF, 8'hF0, 6'b100000, 19'h00000},
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AA, 8'h55, 6'b000000, 19'h00000},
    {19'h00555, 8'h90, 6'b010000, 19'h00000},
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AA, 8'h55, 6'b000000, 19'h00000},
    {19'h00555, 8'hF0, 6'b100000, 19'h00000},
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AB, 8'h55, 6'b000000, 19'h00000},
    {19'h00555, 8'hA0, 6'b000000, 19'h00000},
    {19'h00100, 8'h12, 6'b000000, 19'h00000},
    {19'h7D555, 8'hAA, 6'b000000, 19'h00000},
    {19'h412AA, 8'h55, 6'b000000, 19'h00000},
    {19'h3F555, 8'hA0, 6'b000000, 19'h00000},
    {19'h00000, 8'h77, 6'b000001, 19'h00000},
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AA, 8'h55, 6'b000000, 19'h00000},
    {19'h00555, 8'h80, 6'b000000, 19'h00000},
    {19'h00555, 8'hAA, 6'b000000, 19'h00000},
    {19'h002AA, 8'h00, 6'b000000, 19'h00000},
    {19'h01000, 8'h30, 6'b000000, 19'h00000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sample();
    s_stb  = {id_exit_stb, id_enter_stb, chip_erase_stb, blk_erase_stb,
              sect_erase_stb, prog_stb};
    s_addr = op_addr;
    s_data = op_data;
  endtask

  // one-cycle write window; samples the strobes in the cycle they appear
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic oe_low);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe_low ? 1'b0 : 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sample();
  endtask

  // two-cycle write window with address and data changing mid-window
  task automatic wr2(input logic [AW-1:0] a1, input logic [7:0] d1,
                     input logic [AW-1:0] a2, input logic [7:0] d2);
    @(negedge clk);
    addr = a1; wdata = d1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    addr = a2; wdata = d2;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sample();
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    s_stb  = {5'b0, id_rd_valid};
    s_data = id_rd_data;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock3(input logic [7:0] op);
    wr(19'h00555, 8'hAA, 1'b0);
    wr(19'h002AA, 8'h55, 1'b0);
    wr(19'h00555, op, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 strobes", {id_exit_stb, id_enter_stb, chip_erase_stb, blk_erase_stb,
                       sect_erase_stb, prog_stb}, 0);
    chk("R1 id_mode", id_mode, 0);
    chk("R1 id_rd_valid", id_rd_valid, 0);
    rst = 1'b0;

    // table walk: R3 R4 R5 R6 R7 R8 R10 R11
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][51:33], VEC[i][32:25], 1'b0);
      chk($sformatf("R4-R11 table row %0d strobes", i), s_stb, VEC[i][24:19]);
      if (VEC[i][24:19] != 6'b0 && VEC[i][24:19] != 6'b010000 &&
          VEC[i][24:19] != 6'b100000)
        chk($sformatf("R5 R6 R7 table row %0d op_addr", i), s_addr, VEC[i][18:0]);
    end
    chk("R10 id_mode after walk", id_mode, 0);

    // R13 single-cycle strobe
    unlock3(8'hA0);
    wr(19'h00777, 8'h3C, 1'b0);
    chk("R4 prog data", s_data, 8'h3C);
    @(negedge clk);
    chk("R13 strobe falls", prog_stb, 0);

    // R9 ID reads
    rd(19'h00000);
    chk("R9 read outside id mode", s_stb[0], 0);
    unlock3(8'h90);
    chk("R8 id_mode", id_mode, 1);
    rd(19'h00000);
    chk("R9 mfr valid", s_stb[0], 1);
    chk("R9 mfr code", s_data, 8'h9D);
    rd(19'h40001);
    chk("R9 dev code high bits ignored", s_data, 8'h3E);
    rd(19'h00002);
    chk("R9 other offset", s_data, 8'h00);
    wr(19'h12345, 8'hF0, 1'b0);
    chk("R10 single write exit", s_stb, 6'b100000);
    chk("R10 id_mode cleared", id_mode, 0);
    wr(19'h00000, 8'hF0, 1'b0);
    chk("R10 no exit outside id mode", s_stb, 0);

    // R2 address first cycle, data last cycle
    unlock3(8'hA0);
    wr2(19'h00111, 8'h11, 19'h00222, 8'h22);
    chk("R2 window strobe", s_stb, 6'b000001);
    chk("R2 window address", s_addr, 19'h00111);
    chk("R2 window data", s_data, 8'h22);

    // R2 inhibit: output enable low drops the write
    wr(19'h00555, 8'hAA, 1'b1);
    wr(19'h002AA, 8'h55, 1'b0);
    wr(19'h00555, 8'hA0, 1'b0);
    wr(19'h00050, 8'h44, 1'b0);
    chk("R2 inhibited write", s_stb, 0);

    // R12 busy holds the sequence
    wr(19'h00555, 8'hAA, 1'b0);
    wr(19'h002AA, 8'h55, 1'b0);
    busy = 1'b1;
    wr(19'h00999, 8'h01, 1'b0);
    chk("R12 busy write ignored", s_stb, 0);
    busy = 1'b0;
    wr(19'h00555, 8'hA0, 1'b0);
    wr(19'h00042, 8'h99, 1'b0);
    chk("R12 sequence held strobe", s_stb, 6'b000001);
    chk("R12 sequence held addr", s_addr, 19'h00042);
    chk("R12 sequence held data", s_data, 8'h99);
    busy = 1'b1;
    unlock3(8'h90);
    chk("R12 busy no entry", s_stb, 0);
    chk("R12 busy id_mode", id_mode, 0);
    busy = 1'b0;

    // R1 reset mid-sequence
    wr(19'h00555, 8'hAA, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    wr(19'h002AA, 8'h55, 1'b0);
    wr(19'h00555, 8'hA0, 1'b0);
    wr(19'h00060, 8'h66, 1'b0);
    chk("R1 reset clears sequence", s_stb, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule